// File: doc/BRIEF.md
# General-Purpose I/O Bank with Pin Interrupts

This block serves 32 general-purpose pins behind a small memory-mapped register port. Software sets output levels and enables the drivers pin by pin. It reads back pad levels that have been made safe for the clock domain. Each pin can also act as an interrupt source, sensing either edges or levels of a chosen polarity. Every detected event is latched into a per-pin pending bit. The pending bits that are allowed through are ORed into one bank interrupt line.

The register space has eight registers. Each one is reached at three word addresses: a plain write address, a set address that ORs the written ones into the register, and a clear address that removes the written ones. Software can therefore change single bits without a read-modify-write. A register reads back the same at all three of its addresses. An interrupt reaches the output only when two per-pin bits are both set. The routing bit makes the pin a source, so events are latched only for routed pins. The detect-enable bit lets a latched event through to the output.

Register index is address bits [6:4]: 0 output value, 1 output enable, 2 pad input (read-only), 3 detect enable, 4 routing, 5 sense mode, 6 sense polarity, 7 pending. Address bits [3:2] select the access: 0 plain, 1 set, 2 clear, 3 unused. Address bits [1:0] are ignored. Every bit above [6] must be zero for an access to hit.

Top module: `gpio_bank_irq`

## Requirements
- R1: During and straight after reset, every register reads 0, `pad_oe` is 0 and `irq_out` is 0.
- R2: For the output-value and output-enable registers, a plain write loads the data. A write to the set address (bits [3:2]=1) sets the bits written as 1, and a write to the clear address (bits [3:2]=2) clears them. Bits written as 0 through an alias keep their value. A register reads the same at all three of its addresses.
- R3: `pad_out` carries the output-value register and `pad_oe` carries the output-enable register, both bit for bit. A pin drives its pad only while its enable bit is 1.
- R4: The pad-input register (index 2) shows `pad_in` through two flops, so a change made before clock edge k reads back after edge k+1. Writes to any of its addresses have no effect.
- R5: A routed pin with sense mode 0 and polarity 1 latches its pending bit on a rising pad edge, in the third clock edge after the pad changes. A falling edge does not set the bit. The bit stays set after the pad returns low.
- R6: A routed pin with sense mode 0 and polarity 0 latches on a falling edge and ignores a rising one.
- R7: A routed pin with sense mode 1 sets its pending bit on every clock while the pad is at the active level (polarity 1 high, polarity 0 low). A clear write only sticks once that level has gone.
- R8: `irq_out` is high exactly when some pin has pending, detect-enable and routing bits all 1. Pins that are not routed latch no events. Removing routing or enable drops the output but keeps the pending bit.
- R9: Writing ones to the pending clear address (0x78) clears exactly those pending bits. Zero bits keep their value. An event in the same cycle as the clear keeps its bit set.
- R10: Addresses with access code 3, or with any bit above [6] set, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Raw pad levels, asynchronous |
| pad_out | output | 32 | Output levels to the pads |
| pad_oe | output | 32 | Per-pin driver enable |
| irq_out | output | 1 | Bank interrupt |

## Verification
A corrupted sense or polarity bit shows up at `irq_out` and in the pending register exactly three clock edges after the pad stimulus. It appears as a missing or extra event, so the bench checks each of those three cycles and not only the final result. A broken alias decode shows up at `bus_rdata` and `pad_out` in the cycle after the write, as a bit flipped outside the written mask. A lost history flop or synchroniser stage moves the pending bit by one cycle, and the cycle-exact reads of the input and pending registers report that shift at once.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int unsigned REG_IDX_W = 3;

    typedef enum logic [1:0] {
        ACC_WRITE = 2'd0,
        ACC_SET   = 2'd1,
        ACC_CLEAR = 2'd2,
        ACC_NONE  = 2'd3
    } access_e;

    localparam logic [REG_IDX_W-1:0] IDX_OUT_VAL   = 3'd0;
    localparam logic [REG_IDX_W-1:0] IDX_OUT_EN    = 3'd1;
    localparam logic [REG_IDX_W-1:0] IDX_PAD_IN    = 3'd2;
    localparam logic [REG_IDX_W-1:0] IDX_DET_EN    = 3'd3;
    localparam logic [REG_IDX_W-1:0] IDX_ROUTE     = 3'd4;
    localparam logic [REG_IDX_W-1:0] IDX_SENSE_LVL = 3'd5;
    localparam logic [REG_IDX_W-1:0] IDX_SENSE_POL = 3'd6;
    localparam logic [REG_IDX_W-1:0] IDX_PEND      = 3'd7;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_raw,
    output logic [NPINS-1:0] pin_now,
    output logic [NPINS-1:0] pin_before
);
    typedef struct packed {
        logic [NPINS-1:0] meta;
        logic [NPINS-1:0] safe;
        logic [NPINS-1:0] hist;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pad_raw;
        st_d.safe = st_q.meta;
        st_d.hist = st_q.safe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_now    = st_q.safe;
    assign pin_before = st_q.hist;
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
    parameter int unsigned NPINS = 32
) (
    input  logic [NPINS-1:0] pin_now,
    input  logic [NPINS-1:0] pin_before,
    input  logic [NPINS-1:0] sense_lvl,
    input  logic [NPINS-1:0] sense_pol,
    output logic [NPINS-1:0] pin_event
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise_w, fall_w, level_w;
        assign rise_w  = pin_now[i] & ~pin_before[i];
        assign fall_w  = ~pin_now[i] & pin_before[i];
        assign level_w = (pin_now[i] == sense_pol[i]);
        assign pin_event[i] = sense_lvl[i] ? level_w
                            : (sense_pol[i] ? rise_w : fall_w);
    end
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_now,
    input  logic [NPINS-1:0]  pin_event,
    output logic [NPINS-1:0]  out_val,
    output logic [NPINS-1:0]  out_en,
    output logic [NPINS-1:0]  det_en,
    output logic [NPINS-1:0]  irq_route,
    output logic [NPINS-1:0]  sense_lvl,
    output logic [NPINS-1:0]  sense_pol,
    output logic [NPINS-1:0]  pend
);
    localparam int unsigned IDX_LSB = 4;
    localparam int unsigned TOP_LSB = IDX_LSB + REG_IDX_W;

    typedef struct packed {
        logic [NPINS-1:0] out_val;
        logic [NPINS-1:0] out_en;
        logic [NPINS-1:0] det_en;
        logic [NPINS-1:0] irq_route;
        logic [NPINS-1:0] sense_lvl;
        logic [NPINS-1:0] sense_pol;
        logic [NPINS-1:0] pend;
    } regs_t;

    regs_t rg_d, rg_q;

    logic [REG_IDX_W-1:0] idx;
    access_e              acc;
    logic                 hit;
    logic                 wr_hit;

    assign idx    = bus_addr[IDX_LSB +: REG_IDX_W];
    assign acc    = access_e'(bus_addr[3:2]);
    assign hit    = ((bus_addr >> TOP_LSB) == '0) && (acc != ACC_NONE);
    assign wr_hit = bus_wr && hit;

    function automatic logic [NPINS-1:0] merge(
        input logic [NPINS-1:0] cur,
        input access_e          how,
        input logic [NPINS-1:0] wd
    );
        case (how)
            ACC_WRITE: merge = wd;
            ACC_SET:   merge = cur | wd;
            ACC_CLEAR: merge = cur & ~wd;
            default:   merge = cur;
        endcase
    endfunction

    always_comb begin
        rg_d = rg_q;
        if (wr_hit) begin
            case (idx)
                IDX_OUT_VAL:   rg_d.out_val   = merge(rg_q.out_val,   acc, bus_wdata);
                IDX_OUT_EN:    rg_d.out_en    = merge(rg_q.out_en,    acc, bus_wdata);
                IDX_DET_EN:    rg_d.det_en    = merge(rg_q.det_en,    acc, bus_wdata);
                IDX_ROUTE:     rg_d.irq_route = merge(rg_q.irq_route, acc, bus_wdata);
                IDX_SENSE_LVL: rg_d.sense_lvl = merge(rg_q.sense_lvl, acc, bus_wdata);
                IDX_SENSE_POL: rg_d.sense_pol = merge(rg_q.sense_pol, acc, bus_wdata);
                IDX_PEND:      rg_d.pend      = merge(rg_q.pend,      acc, bus_wdata);
                default:       rg_d = rg_q;
            endcase
        end
        // events on routed pins win over a same-cycle clear
        rg_d.pend = rg_d.pend | (pin_event & rg_q.irq_route);

        bus_rdata = '0;
        if (hit) begin
            case (idx)
                IDX_OUT_VAL:   bus_rdata = rg_q.out_val;
                IDX_OUT_EN:    bus_rdata = rg_q.out_en;
                IDX_PAD_IN:    bus_rdata = pin_now;
                IDX_DET_EN:    bus_rdata = rg_q.det_en;
                IDX_ROUTE:     bus_rdata = rg_q.irq_route;
                IDX_SENSE_LVL: bus_rdata = rg_q.sense_lvl;
                IDX_SENSE_POL: bus_rdata = rg_q.sense_pol;
                default:       bus_rdata = rg_q.pend;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign out_val   = rg_q.out_val;
    assign out_en    = rg_q.out_en;
    assign det_en    = rg_q.det_en;
    assign irq_route = rg_q.irq_route;
    assign sense_lvl = rg_q.sense_lvl;
    assign sense_pol = rg_q.sense_pol;
    assign pend      = rg_q.pend;

    assert_set_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && idx == IDX_OUT_VAL && acc == ACC_SET)
        |=> ((rg_q.out_val & $past(bus_wdata)) == $past(bus_wdata)));

    assert_clear_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && idx == IDX_OUT_VAL && acc == ACC_CLEAR)
        |=> ((rg_q.out_val & $past(bus_wdata)) == '0));

    assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && idx == IDX_PEND && acc != ACC_SET)
        |=> ((rg_q.pend & $past(rg_q.pend)) == $past(rg_q.pend)));
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq_out
);
    logic [NPINS-1:0] pin_now, pin_before, pin_event;
    logic [NPINS-1:0] out_val, out_en, det_en, irq_route;
    logic [NPINS-1:0] sense_lvl, sense_pol, pend;

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pad_raw    (pad_in),
        .pin_now    (pin_now),
        .pin_before (pin_before)
    );

    gpio_event_detect #(.NPINS(NPINS)) u_detect (
        .pin_now    (pin_now),
        .pin_before (pin_before),
        .sense_lvl  (sense_lvl),
        .sense_pol  (sense_pol),
        .pin_event  (pin_event)
    );

    gpio_reg_file #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_now   (pin_now),
        .pin_event (pin_event),
        .out_val   (out_val),
        .out_en    (out_en),
        .det_en    (det_en),
        .irq_route (irq_route),
        .sense_lvl (sense_lvl),
        .sense_pol (sense_pol),
        .pend      (pend)
    );

    assign pad_out = out_val;
    assign pad_oe  = out_en;
    assign irq_out = |(pend & det_en & irq_route);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (irq_out == 1'b0 && pad_oe == '0);
        end
    end

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((det_en & irq_route) == '0) |-> !irq_out);

    assert_edge_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_event & ~sense_lvl) != '0)
        |-> (((pin_now ^ pin_before) & pin_event & ~sense_lvl) == (pin_event & ~sense_lvl)));
endmodule

// File: tb/gpio_bank_irq_test.sv
`timescale 1ns/1ps
module gpio_bank_irq_test;
    localparam int KIND_RD  = 0;
    localparam int KIND_IRQ = 1;
    localparam int KIND_OE  = 2;
    localparam int KIND_OUT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] expv;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;

    always #2.5 clk = ~clk;

    gpio_bank_irq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq_out   (irq_out)
    );

    // monitor: pops expected items and compares with what the design shows
    initial begin
        forever begin
            @(sample_ev);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it = sb_q.pop_front();
                case (it.kind)
                    KIND_IRQ: got = {31'd0, irq_out};
                    KIND_OE:  got = pad_oe;
                    KIND_OUT: got = pad_out;
                    default:  got = bus_rdata;
                endcase
                checks++;
                if (got !== it.expv) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", it.tag, got, it.expv);
                end
            end
        end
    end

    task automatic chk(input int kind, input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        sb_q.push_back('{kind, e, tag});
        ->sample_ev;
        #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_pad(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(KIND_IRQ, 8'h00, 32'h0, "R1 irq in reset");
        chk(KIND_OE, 8'h00, 32'h0, "R1 oe in reset");
        rst_n = 1'b1;
        for (int r = 0; r < 8; r++) chk(KIND_RD, 8'(r * 16), 32'h0, "R1 register after reset");

        // R2/R3 output value and enable through aliases
        wr(8'h00, 32'hA5A5_0F0F);
        chk(KIND_RD, 8'h00, 32'hA5A5_0F0F, "R2 plain write");
        wr(8'h04, 32'h0000_00F0);
        chk(KIND_RD, 8'h04, 32'hA5A5_0FFF, "R2 set alias");
        wr(8'h08, 32'h0000_000F);
        chk(KIND_RD, 8'h08, 32'hA5A5_0FF0, "R2 clear alias");
        chk(KIND_OUT, 8'h00, 32'hA5A5_0FF0, "R3 pad_out");
        wr(8'h14, 32'hFF00_0000);
        chk(KIND_OE, 8'h00, 32'hFF00_0000, "R3 pad_oe set");
        wr(8'h18, 32'h0F00_0000);
        chk(KIND_OE, 8'h00, 32'hF000_0000, "R3 pad_oe clear");
        chk(KIND_RD, 8'h10, 32'hF000_0000, "R2 enable readback");

        // R4 input sync latency and read-only
        set_pad(32'h1234_5678);
        chk(KIND_RD, 8'h20, 32'h0, "R4 one edge later");
        chk(KIND_RD, 8'h20, 32'h1234_5678, "R4 two edges later");
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
        chk(KIND_RD, 8'h20, 32'h1234_5678, "R4 write ignored");
        set_pad(32'h0);
        settle();

        // R5 rising edge on pin 3
        wr(8'h64, 32'h8);
        wr(8'h44, 32'h8);
        wr(8'h34, 32'h8);
        set_pad(32'h8);
        chk(KIND_RD, 8'h70, 32'h0, "R5 pending after edge 1");
        chk(KIND_RD, 8'h70, 32'h0, "R5 pending after edge 2");
        chk(KIND_RD, 8'h70, 32'h8, "R5 pending after edge 3");
        chk(KIND_IRQ, 8'h00, 32'h1, "R5 irq raised");
        set_pad(32'h0);
        settle();
        chk(KIND_RD, 8'h70, 32'h8, "R5 sticky after fall");
        wr(8'h78, 32'h8);
        chk(KIND_RD, 8'h70, 32'h0, "R9 cleared");
        chk(KIND_IRQ, 8'h00, 32'h0, "R9 irq dropped");

        // R6 falling edge on pin 5
        wr(8'h44, 32'h20);
        wr(8'h34, 32'h20);
        set_pad(32'h20);
        settle();
        chk(KIND_RD, 8'h70, 32'h0, "R6 rising ignored");
        set_pad(32'h0);
        settle();
        chk(KIND_RD, 8'h70, 32'h20, "R6 falling latched");
        chk(KIND_IRQ, 8'h00, 32'h1, "R6 irq");
        wr(8'h78, 32'h20);
        chk(KIND_RD, 8'h70, 32'h0, "R6 cleared");

        // R7 active-high level on pin 7
        wr(8'h54, 32'h80);
        wr(8'h64, 32'h80);
        wr(8'h44, 32'h80);
        wr(8'h34, 32'h80);
        set_pad(32'h80);
        settle();
        chk(KIND_RD, 8'h70, 32'h80, "R7 level latched");
        wr(8'h78, 32'h80);
        chk(KIND_RD, 8'h70, 32'h80, "R7 clear refused while active");
        set_pad(32'h0);
        settle();
        chk(KIND_RD, 8'h70, 32'h80, "R7 held after level gone");
        wr(8'h78, 32'h80);
        chk(KIND_RD, 8'h70, 32'h0, "R7 clear sticks");
        chk(KIND_IRQ, 8'h00, 32'h0, "R7 irq low");

        // R8 gating on pin 9 (routed only) and pin 11 (enabled only)
        wr(8'h64, 32'h200);
        wr(8'h44, 32'h200);
        set_pad(32'h200);
        settle();
        chk(KIND_RD, 8'h70, 32'h200, "R8 routed pin latched");
        chk(KIND_IRQ, 8'h00, 32'h0, "R8 no enable no irq");
        wr(8'h34, 32'h200);
        chk(KIND_IRQ, 8'h00, 32'h1, "R8 enable gives irq");
        wr(8'h48, 32'h200);
        chk(KIND_IRQ, 8'h00, 32'h0, "R8 unrouted no irq");
        chk(KIND_RD, 8'h70, 32'h200, "R8 pending kept");
        wr(8'h44, 32'h200);
        chk(KIND_IRQ, 8'h00, 32'h1, "R8 rerouted irq");
        wr(8'h64, 32'h800);
        wr(8'h34, 32'h800);
        set_pad(32'hA00);
        settle();
        chk(KIND_RD, 8'h70, 32'h200, "R8 unrouted pin not latched");

        // R9 clear only written ones
        set_pad(32'hA08);
        settle();
        chk(KIND_RD, 8'h70, 32'h208, "R9 two pending");
        wr(8'h78, 32'h8);
        chk(KIND_RD, 8'h70, 32'h200, "R9 partial clear");
        wr(8'h78, 32'h0);
        chk(KIND_RD, 8'h70, 32'h200, "R9 zero clear");

        // R10 unused addresses
        chk(KIND_RD, 8'h0C, 32'h0, "R10 access code 3 reads 0");
        chk(KIND_RD, 8'h80, 32'h0, "R10 high address reads 0");
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h80, 32'h0);
        chk(KIND_RD, 8'h00, 32'hA5A5_0FF0, "R10 writes ignored");

        @(negedge clk);
        #2;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule